// File: doc/BRIEF.md
# Composite-Field GF(4096) Multiplier

This block multiplies two 12-bit elements of GF(4096). The field is not built as a polynomial basis over GF(2). Instead it is a quadratic extension of GF(64). Each operand is split into a 6-bit high half and a 6-bit low half. The two halves are combined with three subfield products, in the Karatsuba style, plus one multiply by a fixed subfield constant. The subfield products are computed by a six-stage shift-and-add network that has no loops, so the full product is pure combinational logic.

The same datapath also provides a step function of the kind used when Reed-Solomon syndromes and roots are evaluated. Step mode maps zero to one. It maps any other element to that element times the fixed generator constant 0xE01. A result register is optional and is on by default. In that configuration a request presented with `in_valid` is answered one clock later with `out_valid`, and the result stays on `product` until the next answer.

Top module: `gf4096_mult`

## Requirements
- R1: GF(64) products are reduced by x^6 + x + 1. When both operands have bits 11:6 equal to zero, the product is {6'b0, a[5:0]·b[5:0]}. For example, 0x020 · 0x002 = 0x003.
- R2: An element is split so that bits 11:6 hold the coefficient of X and bits 5:0 hold the constant coefficient. The result is packed the same way.
- R3: Bits 11:6 of the product equal (ah^al)·(bh^bl) XOR al·bl, with every product taken in GF(64).
- R4: Bits 5:0 of the product equal (ah·bh)·0x21 XOR al·bl. For example, 0x040 · 0x040 = 0x061.
- R5: With `mode` = 1 (step) and `op_a` = 0, the result is 0x001.
- R6: With `mode` = 1 and a nonzero `op_a`, the result is `op_a` · 0xE01, and `op_b` has no effect on it.
- R7: With `mode` = 0 the product is commutative, and 0x001 is the identity: a · 0x001 = a.
- R8: With the output register on, `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. Reset clears `out_valid` and `product` to 0.
- R9: With the output register on, `product` keeps its last value while no request is accepted, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is present this cycle |
| mode | input | 1 | 0 = general multiply, 1 = step function |
| op_a | input | 12 | First operand, or the step input |
| op_b | input | 12 | Second operand, ignored in step mode |
| out_valid | output | 1 | `product` holds a new result |
| product | output | 12 | Field product or step result |

## Verification
A fault in one subfield product is visible on `product` in the cycle after the request. Where it shows depends on which product is wrong. A bad al·bl term corrupts both halves. A bad cross term corrupts only bits 11:6. A bad constant stage corrupts only bits 5:0, and only when both high halves are nonzero. Operands restricted to the low half, or to pure X terms, therefore point to the faulty product. A broken reduction step shows up only once a shifted term carries past bit 5, so operands with high set bits are required to expose it. A stuck or late result register shows as an answer that is missing, duplicated or shifted by one cycle against the request stream.

// File: rtl/gf_pkg.sv
package gf_pkg;
  parameter int HALF_W = 6;
  parameter int ELEM_W = 2 * HALF_W;
  // x^6 + x + 1 without its leading term
  parameter logic [HALF_W-1:0] SUB_POLY  = 6'h03;
  // constant term of the extension polynomial X^2 + X + c
  parameter logic [HALF_W-1:0] EXT_CONST = 6'h21;
  parameter logic [ELEM_W-1:0] STEP_GEN  = 12'hE01;
  parameter logic [ELEM_W-1:0] ONE       = 12'h001;

  // multiply a subfield element by x, folding the carry back in
  function automatic logic [HALF_W-1:0] sub_xtime(input logic [HALF_W-1:0] v);
    return {v[HALF_W-2:0], 1'b0} ^ (v[HALF_W-1] ? SUB_POLY : '0);
  endfunction

  // compose result halves from the three subfield products
  function automatic logic [ELEM_W-1:0] ext_pack(input logic [HALF_W-1:0] mix,
                                                  input logic [HALF_W-1:0] lo,
                                                  input logic [HALF_W-1:0] hi_scaled);
    return {mix ^ lo, hi_scaled ^ lo};
  endfunction
endpackage

// File: rtl/gf64_mul_net.sv
module gf64_mul_net
  import gf_pkg::*;
(
  input  logic [HALF_W-1:0] a,
  input  logic [HALF_W-1:0] b,
  output logic [HALF_W-1:0] p
);
  logic [HALF_W-1:0] acc [0:HALF_W];
  logic [HALF_W-1:0] shf [0:HALF_W];

  assign acc[0] = '0;
  assign shf[0] = b;

  for (genvar s = 0; s < HALF_W; s++) begin : g_stage
    assign acc[s+1] = a[s] ? (acc[s] ^ shf[s]) : acc[s];
    assign shf[s+1] = sub_xtime(shf[s]);
  end

  assign p = acc[HALF_W];

  // R1: one is the identity of the subfield network
  always_comb begin
    if (a == 6'd1) assert_gf64_identity_R1: assert (p == b);
  end
endmodule

// File: rtl/gf4096_core.sv
module gf4096_core
  import gf_pkg::*;
(
  input  logic [ELEM_W-1:0] x,
  input  logic [ELEM_W-1:0] y,
  output logic [ELEM_W-1:0] z
);
  // R2: bits 11:6 are the X coefficient
  logic [HALF_W-1:0] xh, xl, yh, yl;
  assign xh = x[ELEM_W-1:HALF_W];
  assign xl = x[HALF_W-1:0];
  assign yh = y[ELEM_W-1:HALF_W];
  assign yl = y[HALF_W-1:0];

  logic [HALF_W-1:0] prod_mix, prod_lo, prod_hi, prod_hi_scaled;

  gf64_mul_net u_mix   (.a(xh ^ xl), .b(yh ^ yl), .p(prod_mix));
  gf64_mul_net u_lo    (.a(xl),      .b(yl),      .p(prod_lo));
  gf64_mul_net u_hi    (.a(xh),      .b(yh),      .p(prod_hi));
  gf64_mul_net u_scale (.a(prod_hi), .b(EXT_CONST), .p(prod_hi_scaled));

  // R3, R4
  assign z = ext_pack(prod_mix, prod_lo, prod_hi_scaled);
endmodule

// File: rtl/gf4096_mult.sv
module gf4096_mult
  import gf_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              mode,
  input  logic [ELEM_W-1:0] op_a,
  input  logic [ELEM_W-1:0] op_b,
  output logic              out_valid,
  output logic [ELEM_W-1:0] product
);
  logic              step_zero;
  logic [ELEM_W-1:0] sel_b;
  logic [ELEM_W-1:0] core_z;
  logic [ELEM_W-1:0] result;

  assign step_zero = mode && (op_a == '0);
  assign sel_b     = mode ? STEP_GEN : op_b;   // R6: op_b dropped in step mode

  gf4096_core u_core (.x(op_a), .y(sel_b), .z(core_z));

  assign result = step_zero ? ONE : core_z;    // R5

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        product   <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) product <= result;
      end
    end

    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    assert_step_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode && op_a == '0) |=> product == ONE);
    assert_identity_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mode && op_b == ONE) |=> product == $past(op_a));
    assert_low_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mode && op_a[ELEM_W-1:HALF_W] == '0 && op_b[ELEM_W-1:HALF_W] == '0)
      |=> product[ELEM_W-1:HALF_W] == '0);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(product));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign product   = result;
  end
endmodule

// File: tb/test_gf4096_mult.sv
module test_gf4096_mult;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        mode = 1'b0;
  logic [11:0] op_a = '0;
  logic [11:0] op_b = '0;
  logic        out_valid;
  logic [11:0] product;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [11:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;  // 250 MHz

  gf4096_mult i_gf4096_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product));

  // independent reference: Horner form, MSB of the multiplier first
  function automatic logic [5:0] ref_xt(input logic [5:0] v);
    logic [6:0] w;
    w = {v, 1'b0};
    if (w[6]) w = w ^ 7'h43;
    return w[5:0];
  endfunction

  function automatic logic [5:0] ref64(input logic [5:0] a, input logic [5:0] b);
    logic [5:0] r;
    r = '0;
    for (int i = 5; i >= 0; i--) begin
      r = ref_xt(r);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [11:0] ref4096(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] lo_term, hi_part, lo_part;
    lo_term = ref64(a[5:0], b[5:0]);
    hi_part = ref64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ lo_term;
    lo_part = ref64(ref64(a[11:6], b[11:6]), 6'h21) ^ lo_term;
    return {hi_part, lo_part};
  endfunction

  function automatic logic [11:0] ref_step(input logic [11:0] a);
    return (a == 12'h000) ? 12'h001 : ref4096(a, 12'hE01);
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  // driver: one request per call, expected result queued for the monitor
  task automatic drive(input bit m, input logic [11:0] a, input logic [11:0] b,
                       input logic [11:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1; mode = m; op_a = a; op_b = b;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: pop and compare as results appear
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8 actual=unexpected out_valid expected=no result");
        end else begin
          check(tag_q.pop_front(), product, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] held, ra, rb;
    repeat (3) @(negedge clk);
    check("R8 reset product", product, 12'h000);
    check("R8 reset valid", {11'b0, out_valid}, 12'h000);
    rst_n = 1'b1;

    // R1: low-half-only operands stay in the subfield
    drive(0, 12'h020, 12'h002, 12'h003, "R1 x^5*x");
    drive(0, 12'h03F, 12'h03F, {6'h00, ref64(6'h3F, 6'h3F)}, "R1 full reduce");
    // R2, R4: pure X terms
    drive(0, 12'h040, 12'h040, 12'h061, "R4 X*X");
    drive(0, 12'h040, 12'h001, 12'h040, "R2 X*1");
    // R3: cross term
    drive(0, 12'h041, 12'h080, ref4096(12'h041, 12'h080), "R3 mixed halves");
    drive(0, 12'hFFF, 12'hFFF, ref4096(12'hFFF, 12'hFFF), "R3 all ones");
    // R5, R6 step mode, op_b garbage
    drive(1, 12'h000, 12'hABC, 12'h001, "R5 step zero");
    drive(1, 12'h001, 12'h123, 12'hE01, "R6 step one");
    drive(1, 12'h040, 12'hFFF, ref_step(12'h040), "R6 step X");
    drive(1, 12'h040, 12'h000, ref_step(12'h040), "R6 op_b ignored");
    // R7 identity and zero
    drive(0, 12'hA5C, 12'h001, 12'hA5C, "R7 identity right");
    drive(0, 12'h001, 12'h3E7, 12'h3E7, "R7 identity left");
    drive(0, 12'h000, 12'h9D1, 12'h000, "R3 zero operand");
    idle();

    // random patterns with commutativity pairs
    for (int k = 0; k < 150; k++) begin
      ra = 12'($urandom);
      rb = 12'($urandom);
      drive(0, ra, rb, ref4096(ra, rb), "R3 R4 random");
      drive(0, rb, ra, ref4096(ra, rb), "R7 commutative");
      drive(1, ra, rb, ref_step(ra), "R6 random step");
      if (k % 7 == 0) idle();
    end
    idle();
    @(negedge clk);
    @(negedge clk);
    check("R8 queue drained", 12'(exp_q.size()), 12'h000);

    // R9: held result with moving inputs
    held = product;
    for (int k = 0; k < 4; k++) begin
      op_a = 12'($urandom); op_b = 12'($urandom); mode = k[0];
      @(negedge clk);
      check("R9 hold", product, held);
      check("R8 idle valid", {11'b0, out_valid}, 12'h000);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule